// File: doc/BRIEF.md
# Atomic Compare-and-Swap Unit

This block owns a small word-addressed store and performs atomic compare-and-swap on it. Each request carries a word address, the value the requester expects to find and the value it wants to leave behind. The unit reads the addressed word and compares it with the expected value. It writes the replacement only when the two agree. It then returns a pass/fail status and the word it found.

A wide mode treats an even address and the word above it as one 2-word item. The request then carries two expected values and two replacements. The pair is written only when both words agree, and both are written in the same clock edge. Software can keep a version counter in the upper word beside a data word in the lower one. The wide compare then catches a value that was changed and later changed back, which a single-word compare cannot detect.

A request is taken when the unit is idle. The store is owned by that request until its response has been given, so no other access can slip between the read and the write. The store clears to zero on reset. Any word can be loaded with a swap that expects zero.

Top module: `cas_unit`

## Requirements
- R1: A single-word request (wide flag 0) whose expected value equals the addressed word writes the replacement and responds with ok=1, err=0, and old0 equal to the word before the write.
- R2: A single-word request whose expected value differs from the addressed word leaves the store unchanged and responds with ok=0, err=0, and old0 equal to the current word. A failure is reported only when the word differs.
- R3: A wide request (wide flag 1) at an even address A succeeds only when word A equals exp0 and word A+1 equals exp1. It then writes new0 to A and new1 to A+1 in one edge and reports ok=1 with old0 and old1 holding the prior words.
- R4: A wide request at an even address where either word mismatches writes neither word and reports ok=0, err=0 with both current words in old0 and old1.
- R5: A wide request at an odd address (address bit 0 = 1) writes nothing and responds with ok=0, err=1, old0=0 and old1=0.
- R6: After a request is taken, req_ready is low for exactly three cycles. rsp_valid is high only in the third of those cycles, for one cycle, and req_ready is high again in the next cycle.
- R7: A request presented while req_ready is low is ignored and changes no word.
- R8: After reset, req_ready=1, rsp_valid=0 and every word of the store reads zero.
- R9: A single-word response reports old1=0, and the word above the addressed one is left untouched.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Unit idle; request taken when both are high |
| req_wide | input | 1 | 1 selects the two-word mode |
| req_addr | input | AW ($clog2(DEPTH)) | Word address (even for wide mode) |
| req_exp0 | input | WORD_W | Expected value of the word at the address |
| req_exp1 | input | WORD_W | Expected value of the upper word (wide mode) |
| req_new0 | input | WORD_W | Replacement for the word at the address |
| req_new1 | input | WORD_W | Replacement for the upper word (wide mode) |
| rsp_valid | output | 1 | Response present for one cycle |
| rsp_ok | output | 1 | 1 when the swap was performed |
| rsp_err | output | 1 | 1 for a misaligned wide request |
| rsp_old0 | output | WORD_W | Word found at the address |
| rsp_old1 | output | WORD_W | Upper word found (wide mode), else 0 |

## Verification
A corrupted stored word surfaces at the next request that touches it, either as a wrong old value or as a wrong pass/fail decision. The bench keeps its own copy of the store and probes words after each scenario. A stuck or mis-sequenced controller shows within four cycles of a taken request, because req_ready and rsp_valid are compared on every cycle of every transaction. The counter-guarded replay checks the wide compare end to end: a single-word swap passes on a restored value, and the wide swap must fail because the counter has moved.

// File: rtl/cas_pkg.sv
package cas_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_READ = 2'd1,
        ST_CMP  = 2'd2,
        ST_RSP  = 2'd3
    } cas_state_e;

    // A wide operation must start on an even word address.
    function automatic logic wide_misaligned(input logic wide, input logic addr_lsb);
        return wide & addr_lsb;
    endfunction

endpackage

// File: rtl/cas_ctrl.sv
module cas_ctrl
    import cas_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       req_valid,
    output logic       req_ready,
    output cas_state_e state
);

    cas_state_e state_d;

    always_comb begin
        state_d = state;
        unique case (state)
            ST_IDLE: if (req_valid) state_d = ST_READ;
            ST_READ: state_d = ST_CMP;
            ST_CMP:  state_d = ST_RSP;
            ST_RSP:  state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state <= ST_IDLE;
        else     state <= state_d;
    end

    assign req_ready = (state == ST_IDLE);

    assert_rsp_then_idle_R6: assert property (@(posedge clk) disable iff (rst)
        (state == ST_RSP) |=> (state == ST_IDLE));

endmodule

// File: rtl/cas_store.sv
module cas_store #(
    parameter int WORD_W = 32,
    parameter int DEPTH  = 16
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic [$clog2(DEPTH)-1:0] addr,
    output logic [WORD_W-1:0]        rd0,
    output logic [WORD_W-1:0]        rd1,
    input  logic                     we0,
    input  logic                     we1,
    input  logic [WORD_W-1:0]        wd0,
    input  logic [WORD_W-1:0]        wd1
);

    localparam int AW = $clog2(DEPTH);

    logic [WORD_W-1:0] words [DEPTH];
    logic [AW-1:0]     addr_hi;

    assign addr_hi = addr + AW'(1);

    for (genvar i = 0; i < DEPTH; i++) begin : g_word
        always_ff @(posedge clk) begin
            if (rst)
                words[i] <= '0;
            else if (we0 && addr == AW'(i))
                words[i] <= wd0;
            else if (we1 && addr_hi == AW'(i))
                words[i] <= wd1;
        end
    end

    assign rd0 = words[addr];
    assign rd1 = words[addr_hi];

endmodule

// File: rtl/cas_cmp.sv
module cas_cmp
    import cas_pkg::*;
#(
    parameter int WORD_W = 32
) (
    input  logic              wide,
    input  logic              addr_lsb,
    input  logic [WORD_W-1:0] cur0,
    input  logic [WORD_W-1:0] cur1,
    input  logic [WORD_W-1:0] exp0,
    input  logic [WORD_W-1:0] exp1,
    output logic              match,
    output logic              misaligned
);

    logic lo_eq;
    logic hi_eq;

    assign misaligned = wide_misaligned(wide, addr_lsb);
    assign lo_eq      = (cur0 == exp0);
    assign hi_eq      = (cur1 == exp1);
    assign match      = !misaligned && lo_eq && (!wide || hi_eq);

endmodule

// File: rtl/cas_unit.sv
module cas_unit
    import cas_pkg::*;
#(
    parameter int WORD_W = 32,
    parameter int DEPTH  = 16
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     req_valid,
    output logic                     req_ready,
    input  logic                     req_wide,
    input  logic [$clog2(DEPTH)-1:0] req_addr,
    input  logic [WORD_W-1:0]        req_exp0,
    input  logic [WORD_W-1:0]        req_exp1,
    input  logic [WORD_W-1:0]        req_new0,
    input  logic [WORD_W-1:0]        req_new1,
    output logic                     rsp_valid,
    output logic                     rsp_ok,
    output logic                     rsp_err,
    output logic [WORD_W-1:0]        rsp_old0,
    output logic [WORD_W-1:0]        rsp_old1
);

    localparam int AW = $clog2(DEPTH);

    typedef struct packed {
        logic              wide;
        logic [AW-1:0]     addr;
        logic [WORD_W-1:0] exp0;
        logic [WORD_W-1:0] exp1;
        logic [WORD_W-1:0] new0;
        logic [WORD_W-1:0] new1;
    } req_t;

    typedef struct packed {
        logic              ok;
        logic              err;
        logic [WORD_W-1:0] old0;
        logic [WORD_W-1:0] old1;
    } rsp_t;

    cas_state_e        state;
    req_t              req_q;
    rsp_t              rsp_q;
    logic [WORD_W-1:0] cur0_q, cur1_q;
    logic [WORD_W-1:0] rd0, rd1;
    logic              match, misaligned;
    logic              we0, we1;

    cas_ctrl u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .req_valid (req_valid),
        .req_ready (req_ready),
        .state     (state)
    );

    cas_store #(.WORD_W(WORD_W), .DEPTH(DEPTH)) u_store (
        .clk  (clk),
        .rst  (rst),
        .addr (req_q.addr),
        .rd0  (rd0),
        .rd1  (rd1),
        .we0  (we0),
        .we1  (we1),
        .wd0  (req_q.new0),
        .wd1  (req_q.new1)
    );

    cas_cmp #(.WORD_W(WORD_W)) u_cmp (
        .wide       (req_q.wide),
        .addr_lsb   (req_q.addr[0]),
        .cur0       (cur0_q),
        .cur1       (cur1_q),
        .exp0       (req_q.exp0),
        .exp1       (req_q.exp1),
        .match      (match),
        .misaligned (misaligned)
    );

    assign we0 = (state == ST_CMP) && match;
    assign we1 = we0 && req_q.wide;

    always_ff @(posedge clk) begin
        if (rst) begin
            req_q  <= '0;
            rsp_q  <= '0;
            cur0_q <= '0;
            cur1_q <= '0;
        end else begin
            unique case (state)
                ST_IDLE: if (req_valid)
                    req_q <= '{wide: req_wide, addr: req_addr, exp0: req_exp0,
                               exp1: req_exp1, new0: req_new0, new1: req_new1};
                ST_READ: begin
                    cur0_q <= rd0;
                    cur1_q <= rd1;
                end
                ST_CMP: begin
                    rsp_q.ok   <= match;
                    rsp_q.err  <= misaligned;
                    rsp_q.old0 <= misaligned ? '0 : cur0_q;
                    rsp_q.old1 <= (req_q.wide && !misaligned) ? cur1_q : '0;
                end
                default: ;
            endcase
        end
    end

    assign rsp_valid = (state == ST_RSP);
    assign rsp_ok    = rsp_q.ok;
    assign rsp_err   = rsp_q.err;
    assign rsp_old0  = rsp_q.old0;
    assign rsp_old1  = rsp_q.old1;

    assert_ok_wrote_lo_R1: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && rsp_ok) |-> (rd0 == req_q.new0));

    assert_fail_kept_lo_R2: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && !rsp_ok && !rsp_err) |-> (rd0 == rsp_old0));

    assert_wide_wrote_hi_R3: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && rsp_ok && req_q.wide) |-> (rd1 == req_q.new1));

    assert_wide_fail_kept_hi_R4: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && !rsp_ok && !rsp_err && req_q.wide) |-> (rd1 == rsp_old1));

    assert_misaligned_fails_R5: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && rsp_err) |-> (!rsp_ok && req_q.wide && req_q.addr[0]));

    assert_fixed_latency_R6: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready) |-> ##3 rsp_valid);

    assert_single_pulse_R6: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |=> !rsp_valid);

endmodule

// File: tb/cas_unit_tb_top.sv
module cas_unit_tb_top;

    localparam int WORD_W = 32;
    localparam int DEPTH  = 16;
    localparam int AW     = $clog2(DEPTH);

    logic              clk = 1'b0;
    logic              rst;
    logic              req_valid, req_ready, req_wide;
    logic [AW-1:0]     req_addr;
    logic [WORD_W-1:0] req_exp0, req_exp1, req_new0, req_new1;
    logic              rsp_valid, rsp_ok, rsp_err;
    logic [WORD_W-1:0] rsp_old0, rsp_old1;

    cas_unit #(.WORD_W(WORD_W), .DEPTH(DEPTH)) dut_i (
        .clk(clk), .rst(rst),
        .req_valid(req_valid), .req_ready(req_ready), .req_wide(req_wide),
        .req_addr(req_addr), .req_exp0(req_exp0), .req_exp1(req_exp1),
        .req_new0(req_new0), .req_new1(req_new1),
        .rsp_valid(rsp_valid), .rsp_ok(rsp_ok), .rsp_err(rsp_err),
        .rsp_old0(rsp_old0), .rsp_old1(rsp_old1)
    );

    always #5 clk = ~clk;

    int n_checks = 0;
    int n_fails  = 0;
    bit done     = 1'b0;
    logic [WORD_W-1:0] model [DEPTH];

    task automatic check(input bit cond, input string tag,
                         input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (!cond) begin
            n_fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // One transaction: drive, model, then compare every cycle until idle again.
    task automatic do_cas(input bit wide, input int addr,
                          input logic [WORD_W-1:0] e0, input logic [WORD_W-1:0] e1,
                          input logic [WORD_W-1:0] n0, input logic [WORD_W-1:0] n1,
                          input bit noise, input string tag);
        bit mis, eok;
        logic [WORD_W-1:0] o0, o1;
        int hi;
        @(negedge clk);
        check(req_ready === 1'b1, {tag, " R6 idle before request"}, req_ready, 1);
        req_valid = 1'b1; req_wide = wide; req_addr = AW'(addr);
        req_exp0 = e0; req_exp1 = e1; req_new0 = n0; req_new1 = n1;
        @(posedge clk);
        hi  = (addr + 1) % DEPTH;
        mis = wide && (addr % 2 == 1);
        if (mis) begin
            eok = 1'b0; o0 = '0; o1 = '0;
        end else begin
            o0  = model[addr];
            o1  = wide ? model[hi] : '0;
            eok = (o0 == e0) && (!wide || o1 == e1);
            if (eok) begin
                model[addr] = n0;
                if (wide) model[hi] = n1;
            end
        end
        for (int k = 1; k <= 3; k++) begin
            @(negedge clk);
            if (k == 1 && noise) begin
                // R7: a competing request while busy; would succeed if taken
                req_valid = 1'b1; req_wide = 1'b0; req_addr = '0;
                req_exp0 = model[0]; req_new0 = 32'hDEAD_0000;
            end else if (k == 1 || k == 3) begin
                req_valid = noise && k == 1;
            end
            if (k == 3) req_valid = 1'b0;
            check(req_ready === 1'b0, {tag, " R6 busy"}, req_ready, 0);
            check(rsp_valid === (k == 3), {tag, " R6 rsp_valid timing"}, rsp_valid, k == 3);
            if (k == 3) begin
                check(rsp_ok === eok, {tag, " ok"}, rsp_ok, eok);
                check(rsp_err === mis, {tag, " R5 err"}, rsp_err, mis);
                check(rsp_old0 === o0, {tag, " old0"}, rsp_old0, o0);
                check(rsp_old1 === o1, {tag, " old1 (R9 for single)"}, rsp_old1, o1);
            end
        end
        @(negedge clk);
        check(req_ready === 1'b1, {tag, " R6 ready again"}, req_ready, 1);
        check(rsp_valid === 1'b0, {tag, " R6 rsp dropped"}, rsp_valid, 0);
    endtask

    // Read a word without changing it: a swap of the model value with itself.
    task automatic probe(input int addr, input string tag);
        do_cas(1'b0, addr, model[addr], '0, model[addr], '0, 1'b0, tag);
    endtask

    initial begin
        for (int i = 0; i < DEPTH; i++) model[i] = '0;
        rst = 1'b1; req_valid = 1'b0; req_wide = 1'b0; req_addr = '0;
        req_exp0 = '0; req_exp1 = '0; req_new0 = '0; req_new1 = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        check(req_ready === 1'b1, "R8 ready after reset", req_ready, 1);
        check(rsp_valid === 1'b0, "R8 no response after reset", rsp_valid, 0);

        do_cas(1'b0, 3, 32'h0, 0, 32'h11, 0, 1'b0, "R1 R8 single swap on cleared word");
        do_cas(1'b0, 3, 32'h5, 0, 32'h99, 0, 1'b0, "R2 single mismatch");
        probe(3, "R2 word kept");
        probe(4, "R9 neighbour untouched");
        do_cas(1'b1, 4, 0, 0, 32'hA0A0, 32'hB1B1, 1'b0, "R3 wide swap");
        do_cas(1'b1, 4, 32'hA0A0, 32'h1, 32'h1, 32'h2, 1'b0, "R4 upper mismatch");
        do_cas(1'b1, 4, 32'h7, 32'hB1B1, 32'h1, 32'h2, 1'b0, "R4 lower mismatch");
        probe(5, "R4 upper kept");
        do_cas(1'b1, 5, 32'hB1B1, 0, 32'h3, 32'h3, 1'b1, "R5 R7 misaligned wide with busy request");
        probe(0, "R7 busy request ignored");
        probe(5, "R5 nothing written");
        do_cas(1'b1, 14, 0, 0, 32'hEE, 32'hFF, 1'b0, "R3 wide at top pair");
        do_cas(1'b0, 15, 32'hFF, 0, 32'h1234, 0, 1'b0, "R9 single at last word");
        probe(0, "R9 wrap word untouched");

        // Value changed away and back: the counter word exposes it (R3)
        do_cas(1'b1, 8, 0, 0, 32'hCAFE, 32'd0, 1'b0, "R3 ABA setup");
        do_cas(1'b1, 8, 32'hCAFE, 32'd0, 32'hBEEF, 32'd1, 1'b0, "R3 ABA change");
        do_cas(1'b1, 8, 32'hBEEF, 32'd1, 32'hCAFE, 32'd2, 1'b0, "R3 ABA restore");
        do_cas(1'b0, 8, 32'hCAFE, 0, 32'h5555, 0, 1'b0, "R1 stale single swap passes");
        do_cas(1'b0, 8, 32'h5555, 0, 32'hCAFE, 0, 1'b0, "R1 put value back");
        do_cas(1'b1, 8, 32'hCAFE, 32'd0, 32'h5555, 32'd1, 1'b0, "R4 stale wide swap fails");
        probe(8, "R4 data word kept");
        probe(9, "R4 counter kept");

        for (int i = 0; i < 6; i++)
            do_cas(i % 2 == 1, 2 * i, model[2 * i], model[2 * i + 1],
                   32'h100 + i, 32'h200 + i, 1'b0, "R3 R1 sweep");

        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_checks++;
            n_fails++;
            $display("FAIL watchdog R6 actual=hung expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
            $finish;
        end
    end

endmodule